// File: doc/BRIEF.md
# Dual Loopback Path Selector

This block chooses what feeds the transmit side of a framed line interface, so that the interface can run two kinds of loopback. With payload loopback on, the recovered receive payload goes into the transmit framer input. That payload has already been decoded, had its framing recovered and had its overhead removed. The framer then frames it again and the encoder line-codes it again. With remote line loopback on, decoded receive line words go straight into the transmit line encoder input. The source of those words is the line decoder output, or the receive FIFO output when that FIFO is enabled. With both loopbacks off, the normal transmit payload and the normal framer output pass through unchanged.

A host writes one 8-bit control register. A write that changes either loopback bit makes the block drive both transmit outputs to zero for a short settling window. The same write raises a busy flag. The flag stays high until a lockout counter has counted a fixed number of cycles of the slowest clock. The write request reaches that clock domain through a two-flop synchroniser, and the end-of-count indication comes back the same way. The block ignores any host read or write made while busy is high, and each such access sets a sticky fault flag. The receive payload and the receive line words leave the block unchanged whatever loopback is selected.

Top module: `loopback_path_select`

## Requirements
- R1: After reset the control register reads 0x00, busy and the fault flag are low, framerIn follows txPayload and encoderIn follows txLine, each one host cycle later.
- R2: When bit 7 (payload loopback) is set, framerIn carries rxPayload one host cycle later.
- R3: When bit 6 (line loopback) is set and rxFifoEn is low, encoderIn carries decData one host cycle later.
- R4: When bit 6 is set and rxFifoEn is high, encoderIn carries fifoData one host cycle later.
- R5: encLcv follows txLcvReq one cycle later when line loopback is off, and is forced low while line loopback is on, so receive code violations are never re-created.
- R6: rxPayloadOut and rxLineOut equal rxPayload and decData one cycle later, whatever the loopback settings.
- R7: With bits 7 and 6 both set, the encoder takes the line-loopback source and the framer keeps the receive payload.
- R8: An accepted write that changes bit 7 or bit 6 raises hostBusy from the next cycle. hostBusy stays high for at least LOCK_CYCLES slow-clock periods and then falls by itself. An accepted write that leaves both bits unchanged does not raise hostBusy.
- R9: A write or read made while hostBusy is high changes neither the register nor regRdata.
- R10: Each access made while busy sets accessFault, which also reads back as bit 0. The fault is cleared only by the next accepted read, which still returns it as set.
- R11: For SETTLE_CYCLES host cycles after a loopback change, framerIn and encoderIn are driven to zero.
- R12: Bits 5 to 1 of the control register always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host and datapath clock |
| slowClk | input | 1 | Slowest clock; the lockout counter runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Write data; bit 7 payload loopback, bit 6 line loopback |
| regRdata | output | 8 | Read data, updated the cycle after an accepted read |
| hostBusy | output | 1 | High while host accesses are locked out |
| accessFault | output | 1 | Sticky flag for an access made during lockout |
| rxFifoEn | input | 1 | Receive FIFO enabled; selects the line-loopback source |
| txPayload | input | PW | Normal transmit payload |
| rxPayload | input | PW | Recovered receive payload |
| txLine | input | LW | Normal framer output toward the encoder |
| txLcvReq | input | 1 | Request to insert a code violation on transmit |
| decData | input | LW | Line decoder output |
| fifoData | input | LW | Receive FIFO output |
| framerIn | output | PW | Selected framer input |
| encoderIn | output | LW | Selected encoder input |
| encLcv | output | 1 | Code-violation insert toward the encoder |
| rxPayloadOut | output | PW | Receive payload passed on |
| rxLineOut | output | LW | Decoded line word passed on |

## Verification
The properties assume that inputs change only between host clock edges and that the host raises no strobe while reset is active. The bench therefore drives every input on the falling edge and holds the strobes low during reset. The busy-length check also assumes the slow clock is the slower of the two clocks. The bench keeps a fixed ratio of six host cycles to one slow cycle and allows for synchroniser delay on both crossings. The bench draws data and rxFifoEn values at random for each cycle and draws loopback settings at random for each configuration. It waits for busy to fall before it checks the data paths, so that only the directed cases touch the settling window.

// File: rtl/lpsel_pkg.sv
package lpsel_pkg;
  // control strobes handed from the control unit to the datapath
  typedef struct packed {
    logic payLp;   // framer input fed from receive payload
    logic lineLp;  // encoder input fed from receive line words
    logic blank;   // settling window after a loopback change
  } lpCtl_t;

  localparam int PAY_BIT   = 7;
  localparam int LINE_BIT  = 6;
  localparam int FAULT_BIT = 0;
  localparam int REG_W     = 8;
endpackage

// File: rtl/lpsel_sync.sv
module lpsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stageQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= {stageQ[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stageQ[STAGES-1];
endmodule

// File: rtl/lpsel_ctrl.sv
module lpsel_ctrl
  import lpsel_pkg::*;
#(
  parameter int LOCK_CYCLES   = 20,
  parameter int SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             hostClk,
  input  logic             slowClk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             hostBusy,
  output logic             accessFault,
  output lpCtl_t           ctl
);
  localparam int SW  = $clog2(SETTLE_CYCLES + 1);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);

  // ---------------- host domain ----------------
  logic          payQ, lineQ, faultQ, busyQ;
  logic [SW-1:0] settleCnt;
  logic          reqTgl;
  logic          doneSyncQ, doneSeen;
  logic          wrOk, rdOk, bitsChange, doneEdge;

  assign wrOk       = regWr && !busyQ;
  assign rdOk       = regRd && !busyQ;
  assign bitsChange = (regWdata[PAY_BIT] != payQ) || (regWdata[LINE_BIT] != lineQ);
  assign doneEdge   = doneSyncQ ^ doneSeen;

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      payQ      <= 1'b0;
      lineQ     <= 1'b0;
      busyQ     <= 1'b0;
      reqTgl    <= 1'b0;
      settleCnt <= '0;
      doneSeen  <= 1'b0;
    end else begin
      doneSeen <= doneSyncQ;
      if (wrOk) begin
        payQ  <= regWdata[PAY_BIT];
        lineQ <= regWdata[LINE_BIT];
      end
      if (wrOk && bitsChange) begin
        busyQ     <= 1'b1;
        reqTgl    <= ~reqTgl;
        settleCnt <= SW'(SETTLE_CYCLES);
      end else begin
        if (doneEdge) busyQ <= 1'b0;
        if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      faultQ   <= 1'b0;
      regRdata <= '0;
    end else begin
      if (busyQ && (regWr || regRd)) faultQ <= 1'b1;
      else if (rdOk)                 faultQ <= 1'b0;
      if (rdOk) begin
        regRdata            <= '0;
        regRdata[PAY_BIT]   <= payQ;
        regRdata[LINE_BIT]  <= lineQ;
        regRdata[FAULT_BIT] <= faultQ;
      end
    end
  end

  // ---------------- slow domain ----------------
  logic           reqSyncQ, reqSeen, doneTgl;
  logic [LCW-1:0] lockCnt;

  lpsel_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(slowClk), .rstN(rstN), .d(reqTgl), .q(reqSyncQ)
  );

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      lockCnt <= '0;
      doneTgl <= 1'b0;
    end else begin
      reqSeen <= reqSyncQ;
      if (reqSyncQ ^ reqSeen) begin
        lockCnt <= LCW'(LOCK_CYCLES);
      end else if (lockCnt != '0) begin
        lockCnt <= lockCnt - 1'b1;
        if (lockCnt == LCW'(1)) doneTgl <= ~doneTgl;
      end
    end
  end

  lpsel_sync #(.STAGES(SYNC_STAGES)) u_doneSync (
    .clk(hostClk), .rstN(rstN), .d(doneTgl), .q(doneSyncQ)
  );

  assign hostBusy    = busyQ;
  assign accessFault = faultQ;
  assign ctl.payLp   = payQ;
  assign ctl.lineLp  = lineQ;
  assign ctl.blank   = (settleCnt != '0);
endmodule

// File: rtl/lpsel_datapath.sv
module lpsel_datapath
  import lpsel_pkg::*;
#(
  parameter int PW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  lpCtl_t        ctl,
  input  logic          fifoEn,
  input  logic [PW-1:0] txPayload,
  input  logic [PW-1:0] rxPayload,
  input  logic [LW-1:0] txLine,
  input  logic          txLcvReq,
  input  logic [LW-1:0] decData,
  input  logic [LW-1:0] fifoData,
  output logic [PW-1:0] framerIn,
  output logic [LW-1:0] encoderIn,
  output logic          encLcv,
  output logic [PW-1:0] rxPayloadOut,
  output logic [LW-1:0] rxLineOut
);
  logic [PW-1:0] framerSel;
  logic [LW-1:0] lineSrc, encSel;

  always_comb begin
    framerSel = ctl.payLp ? rxPayload : txPayload;
    lineSrc   = fifoEn ? fifoData : decData;
    encSel    = ctl.lineLp ? lineSrc : txLine;
    if (ctl.blank) begin
      framerSel = '0;
      encSel    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framerIn     <= '0;
      encoderIn    <= '0;
      encLcv       <= 1'b0;
      rxPayloadOut <= '0;
      rxLineOut    <= '0;
    end else begin
      framerIn     <= framerSel;
      encoderIn    <= encSel;
      encLcv       <= txLcvReq && !ctl.lineLp;
      rxPayloadOut <= rxPayload;
      rxLineOut    <= decData;
    end
  end
endmodule

// File: rtl/loopback_path_select.sv
module loopback_path_select
  import lpsel_pkg::*;
#(
  parameter int PW            = 16,
  parameter int LW            = 8,
  parameter int LOCK_CYCLES   = 20,
  parameter int SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          hostClk,
  input  logic          slowClk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  output logic          hostBusy,
  output logic          accessFault,
  input  logic          rxFifoEn,
  input  logic [PW-1:0] txPayload,
  input  logic [PW-1:0] rxPayload,
  input  logic [LW-1:0] txLine,
  input  logic          txLcvReq,
  input  logic [LW-1:0] decData,
  input  logic [LW-1:0] fifoData,
  output logic [PW-1:0] framerIn,
  output logic [LW-1:0] encoderIn,
  output logic          encLcv,
  output logic [PW-1:0] rxPayloadOut,
  output logic [LW-1:0] rxLineOut
);
  lpCtl_t ctlBus;

  lpsel_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .hostClk(hostClk), .slowClk(slowClk), .rstN(rstN),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .hostBusy(hostBusy), .accessFault(accessFault), .ctl(ctlBus)
  );

  lpsel_datapath #(.PW(PW), .LW(LW)) u_dp (
    .clk(hostClk), .rstN(rstN), .ctl(ctlBus), .fifoEn(rxFifoEn),
    .txPayload(txPayload), .rxPayload(rxPayload), .txLine(txLine),
    .txLcvReq(txLcvReq), .decData(decData), .fifoData(fifoData),
    .framerIn(framerIn), .encoderIn(encoderIn), .encLcv(encLcv),
    .rxPayloadOut(rxPayloadOut), .rxLineOut(rxLineOut)
  );
endmodule

// File: rtl/lpsel_chk.sv
module lpsel_chk
  import lpsel_pkg::*;
#(
  parameter int PW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWr,
  input logic          regRd,
  input logic [7:0]    regRdata,
  input logic          hostBusy,
  input logic          accessFault,
  input logic          rxFifoEn,
  input logic [PW-1:0] rxPayload,
  input logic [LW-1:0] decData,
  input logic [LW-1:0] fifoData,
  input logic [PW-1:0] framerIn,
  input logic [LW-1:0] encoderIn,
  input logic          encLcv,
  input logic [PW-1:0] rxPayloadOut,
  input lpCtl_t        ctl
);
  // R2
  pay_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.payLp && !ctl.blank) |=> framerIn == $past(rxPayload));
  // R3
  line_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineLp && !ctl.blank && !rxFifoEn) |=> encoderIn == $past(decData));
  // R4
  line_fifo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineLp && !ctl.blank && rxFifoEn) |=> encoderIn == $past(fifoData));
  // R5
  no_lcv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineLp |=> !encLcv);
  // R6
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rxPayloadOut == $past(rxPayload));
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostBusy) |-> $past(regWr));
  // R9
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostBusy && (regWr || regRd)) |=> ($stable({ctl.payLp, ctl.lineLp}) && $stable(regRdata)));
  // R10
  fault_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostBusy && (regWr || regRd)) |=> accessFault);
  // R11
  blank_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blank |=> (framerIn == '0 && encoderIn == '0));
  // R12
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[5:1] == 5'b0);
endmodule

bind loopback_path_select lpsel_chk #(.PW(PW), .LW(LW)) chk (
  .clk(hostClk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
  .hostBusy(hostBusy), .accessFault(accessFault), .rxFifoEn(rxFifoEn),
  .rxPayload(rxPayload), .decData(decData), .fifoData(fifoData),
  .framerIn(framerIn), .encoderIn(encoderIn), .encLcv(encLcv),
  .rxPayloadOut(rxPayloadOut), .ctl(ctlBus)
);

// File: tb/loopback_path_select_test.sv
`timescale 1ns/1ps
module loopback_path_select_test;
  localparam int PW = 16;
  localparam int LW = 8;
  localparam int LOCK = 20;
  localparam int RATIO = 6;

  logic hostClk = 0, slowClk = 0, rstN = 0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic hostBusy, accessFault, rxFifoEn = 0, txLcvReq = 0, encLcv;
  logic [PW-1:0] txPayload = 0, rxPayload = 0, framerIn, rxPayloadOut;
  logic [LW-1:0] txLine = 0, decData = 0, fifoData = 0, encoderIn, rxLineOut;

  int compared = 0, mismatched = 0;
  bit cfgPay = 0, cfgLine = 0;
  logic [7:0] lastRd = 0;

  always #2.5 hostClk = ~hostClk;
  always #15  slowClk = ~slowClk;

  loopback_path_select #(.PW(PW), .LW(LW), .LOCK_CYCLES(LOCK)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] expFramer(bit pay, logic [PW-1:0] tx, logic [PW-1:0] rx);
    return pay ? rx : tx;
  endfunction
  function automatic logic [LW-1:0] expEnc(bit line, bit fe, logic [LW-1:0] tl,
                                           logic [LW-1:0] dd, logic [LW-1:0] fd);
    return line ? (fe ? fd : dd) : tl;
  endfunction

  task automatic randData();
    txPayload = PW'($urandom); rxPayload = PW'($urandom);
    txLine = LW'($urandom); decData = LW'($urandom); fifoData = LW'($urandom);
    txLcvReq = 1'($urandom); rxFifoEn = 1'($urandom);
  endtask

  task automatic dataCycle();
    logic [PW-1:0] eF, rxP; logic [LW-1:0] eE, dd; logic eL;
    randData();
    eF = expFramer(cfgPay, txPayload, rxPayload);
    eE = expEnc(cfgLine, rxFifoEn, txLine, decData, fifoData);
    eL = txLcvReq && !cfgLine;
    rxP = rxPayload; dd = decData;
    @(negedge hostClk);
    check(cfgPay ? "R2 framer" : "R1 framer", 32'(framerIn), 32'(eF));
    check(cfgLine ? (rxFifoEn ? "R4 encoder" : "R3 encoder") : "R1 encoder", 32'(encoderIn), 32'(eE));
    if (cfgPay && cfgLine) check("R7 both framer", 32'(framerIn), 32'(eF));
    check("R5 lcv", 32'(encLcv), 32'(eL));
    check("R6 rx payload", 32'(rxPayloadOut), 32'(rxP));
    check("R6 rx line", 32'(rxLineOut), 32'(dd));
  endtask

  task automatic doWrite(input logic [7:0] v);
    regWr = 1; regWdata = v;
    @(negedge hostClk);
    regWr = 0;
  endtask

  task automatic doRead(output logic [7:0] v);
    regRd = 1;
    @(negedge hostClk);
    regRd = 0;
    v = regRdata;
  endtask

  task automatic waitIdle(output int d);
    d = 0;
    while (hostBusy && d < 2000) begin
      @(negedge hostClk);
      d++;
    end
  endtask

  // accepted write that changes loopback bits: checks R8 and R11, then waits
  task automatic changeCfg(input bit p, input bit l, input bit full);
    int d;
    doWrite({p, l, 6'b0});
    cfgPay = p; cfgLine = l;
    check("R8 busy raised", 32'(hostBusy), 32'd1);
    randData();
    @(negedge hostClk);
    if (full) begin
      check("R11 framer blank", 32'(framerIn), 32'd0);
      check("R11 encoder blank", 32'(encoderIn), 32'd0);
    end
    waitIdle(d);
    d = d + 1;
    if (full) begin
      check("R8 busy long enough", 32'(d >= LOCK * RATIO), 32'd1);
      check("R8 busy released", 32'(d <= LOCK * RATIO + 40), 32'd1);
    end
  endtask

  initial begin
    logic [7:0] v;
    int d;
    void'($urandom(32'd1234));
    repeat (5) @(negedge hostClk);
    rstN = 1;
    @(negedge hostClk);
    // R1 reset state
    check("R1 busy", 32'(hostBusy), 32'd0);
    check("R1 fault", 32'(accessFault), 32'd0);
    doRead(v); lastRd = v;
    check("R1 register", 32'(v), 32'h00);
    repeat (4) dataCycle();

    // R8 unchanged bits: no lockout
    doWrite(8'h3E);
    check("R8 no busy on same bits", 32'(hostBusy), 32'd0);

    // R8/R11 change, R9/R10 accesses while locked
    doWrite(8'hFF);
    cfgPay = 1; cfgLine = 1;
    check("R8 busy raised", 32'(hostBusy), 32'd1);
    randData();
    @(negedge hostClk);
    check("R11 framer blank", 32'(framerIn), 32'd0);
    check("R11 encoder blank", 32'(encoderIn), 32'd0);
    doRead(v);
    check("R9 read ignored", 32'(v), 32'(lastRd));
    check("R10 fault set", 32'(accessFault), 32'd1);
    doWrite(8'h00);
    waitIdle(d);
    check("R8 busy long enough", 32'(d + 3 >= LOCK * RATIO), 32'd1);
    check("R8 busy released", 32'(hostBusy), 32'd0);
    doRead(v);
    check("R9 write ignored / R10 fault bit / R12", 32'(v), 32'hC1);
    check("R10 fault cleared", 32'(accessFault), 32'd0);
    doRead(v);
    check("R10 fault read clear / R12", 32'(v), 32'hC0);
    lastRd = v;
    repeat (8) dataCycle();   // R7 both enabled

    // random configurations
    for (int c = 0; c < 12; c++) begin
      bit p, l;
      p = 1'($urandom); l = 1'($urandom);
      if (p == cfgPay && l == cfgLine) l = ~l;
      changeCfg(p, l, (c % 3) == 0);
      repeat (40) dataCycle();
      doRead(v);
      check("R12 readback", 32'(v), 32'({cfgPay, cfgLine, 6'b0}));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule